// File: doc/BRIEF.md
# Buffered SPI Master Channel

This block is an 8-bit SPI master with a one-byte holding register on each side of a single shift register. Bytes to be sent arrive on a valid/ready stream and wait in the transmit holder. The shift engine picks up a waiting byte as soon as it is free, and shifts it out MSB first on `mosi`. In the same bit slots it shifts in `miso`. Each finished byte goes to the receive holder, which is offered on a second valid/ready stream.

A receive-only transfer is done by pushing a dummy byte. The serial clock runs from a prescaled clock-enable, and the polarity and phase follow two plain select pins. A single level interrupt combines two causes, each with its own enable: transmit holder empty and receive holder full. Software tells the causes apart from the status pins. Clearing the enable pin aborts any transfer in progress and empties both holders.

Back-pressure rules:
- Transmit side: a byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while the holder is occupied or the channel is disabled.
- Receive side: `rx_valid` stays high until a clock edge where `rx_ready` is also high. The serial side never waits for the consumer. A byte that finishes while the holder is still full replaces the old byte and raises the overrun flag.

Top module: `spi_buf_master`

## Requirements
- R1: `tx_ready` equals `cfg_enable` AND (transmit holder empty). An accepted byte makes `st_tx_empty` read 0 from the next clock edge on.
- R2: When the holder is full and the engine is idle, the byte moves to the shift register on the next edge. On that same edge `st_busy` rises and `st_tx_empty` returns to 1.
- R3: Each transfer shifts 8 bits MSB first on `mosi`. It captures 8 bits MSB first from `miso` in the same bit slots, so a dummy write returns the received byte.
- R4: The leading edge is the first `sclk` edge away from the idle level. With `cfg_cpha`=0, `mosi` is valid before the leading edge, `miso` is sampled on the leading edge, and `mosi` changes on the trailing edge. With `cfg_cpha`=1, `mosi` changes on the leading edge and `miso` is sampled on the trailing edge.
- R5: `sclk` equals `cfg_cpol` whenever no transfer is active. Each byte makes exactly 16 `sclk` transitions, which are 8 full clocks. Each half period lasts `cfg_div`+1 clock cycles.
- R6: A finished byte appears on `rx_data`, with `rx_valid` and `st_rx_full` set, on the clock edge of the eighth bit's final `sclk` edge. A handshake with `rx_ready` clears the flag.
- R7: A byte that finishes while the receive holder is full overwrites `rx_data` and sets `st_overrun`. A receive handshake or a disable clears `st_overrun`.
- R8: If a byte waits in the transmit holder when a transfer ends, the next transfer starts on the same edge. `st_busy` stays high, and all `sclk` transitions across both bytes stay `cfg_div`+1 cycles apart.
- R9: For a single byte, `st_busy` is high for exactly 16×(`cfg_div`+1) cycles, starting at the load edge.
- R10: `irq` = (`cfg_tx_ie` AND `cfg_enable` AND `st_tx_empty`) OR (`cfg_rx_ie` AND `st_rx_full`). With both enables at 0, `irq` stays 0.
- R11: Driving `cfg_enable` low aborts the transfer in progress and clears both holders and the overrun flag on the next edge. A byte that was waiting is never sent.
- R12: After reset, the outputs read as follows: `st_busy`=0, `st_rx_full`=0, `st_overrun`=0, `st_tx_empty`=1, `irq`=0, and `sclk`=`cfg_cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Channel enable; low flushes both holders |
| cfg_cpol | input | 1 | Idle level of `sclk` |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_div | input | DIV_W | Half-period of `sclk` minus one, in clock cycles |
| cfg_tx_ie | input | 1 | Interrupt enable for transmit holder empty |
| cfg_rx_ie | input | 1 | Interrupt enable for receive holder full |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit holder can accept |
| tx_data | input | DATA_W | Transmit byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes received byte |
| rx_data | output | DATA_W | Received byte |
| st_tx_empty | output | 1 | Transmit holder empty flag |
| st_rx_full | output | 1 | Receive holder full flag |
| st_busy | output | 1 | Shift register transferring |
| st_overrun | output | 1 | Received byte overwritten before being taken |
| irq | output | 1 | Combined interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A bad edge counter or phase state would show up at the pins almost at once. It leaves `sclk` off its idle level, or gives the wrong number of transitions. It also produces a bit-reversed or shifted byte, and these are visible at the first `rx_valid`, within 16×(`cfg_div`+1) cycles. Holder flag errors surface within one or two edges:
- `tx_ready` and `st_tx_empty` disagree with the handshake.
- `st_busy` fails to rise on the load edge.
- A gap appears in `sclk` between back-to-back bytes.

Overrun and flush faults show up as a stale or surviving `rx_data` byte, or as a discarded byte being sent after re-enable.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;
  typedef struct packed {
    logic cpol;
    logic cpha;
  } spi_mode_t;
endpackage

// File: rtl/spi_prescaler.sv
module spi_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // R5
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));
endmodule

// File: rtl/spi_tx_holder.sv
module spi_tx_holder #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (!enable) begin
      full <= 1'b0;
    end else if (pop) begin
      full <= 1'b0;
    end else if (push) begin
      full <= 1'b1;
      data <= push_data;
    end
  end

  // R11
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !full);
  // R2
  tx_pop_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> !full);
endmodule

// File: rtl/spi_rx_holder.sv
module spi_rx_holder #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              done,
  input  logic [DATA_W-1:0] done_word,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              overrun
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full    <= 1'b0;
      data    <= '0;
      overrun <= 1'b0;
    end else if (!enable) begin
      full    <= 1'b0;
      overrun <= 1'b0;
    end else if (done) begin
      data <= done_word;
      full <= 1'b1;
      if (full && !take) overrun <= 1'b1;
      else if (take)     overrun <= 1'b0;
    end else if (take) begin
      full    <= 1'b0;
      overrun <= 1'b0;
    end
  end

  // R7
  overrun_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> full);
  // R6
  rx_take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !done && enable) |=> !full);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_buf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  spi_mode_t         mode,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] word,
  output logic              sclk,
  output logic              mosi
);
  localparam int EDGES = 2 * DATA_W;
  localparam int CW    = $clog2(EDGES);

  logic [CW-1:0]     edge_cnt;
  logic              phase;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic              lead, last, sample_now, shift_now;

  assign lead       = !edge_cnt[0];
  assign last       = (edge_cnt == CW'(EDGES - 1));
  assign done       = busy && tick && last;
  assign sample_now = mode.cpha ? !lead : lead;
  assign shift_now  = mode.cpha ? lead : (!lead && !last);
  assign word       = mode.cpha ? {rx_sh[DATA_W-2:0], miso} : rx_sh;
  assign sclk       = mode.cpol ^ phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      edge_cnt <= '0;
      phase    <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      mosi     <= 1'b0;
    end else if (!enable) begin
      busy     <= 1'b0;
      edge_cnt <= '0;
      phase    <= 1'b0;
    end else if (load) begin
      busy     <= 1'b1;
      edge_cnt <= '0;
      phase    <= 1'b0;
      rx_sh    <= '0;
      if (!mode.cpha) begin
        mosi  <= load_data[DATA_W-1];
        tx_sh <= load_data << 1;
      end else begin
        tx_sh <= load_data;
      end
    end else if (busy && tick) begin
      phase    <= ~phase;
      edge_cnt <= edge_cnt + 1'b1;
      if (last) busy <= 1'b0;
      if (sample_now) rx_sh <= {rx_sh[DATA_W-2:0], miso};
      if (shift_now) begin
        mosi  <= tx_sh[DATA_W-1];
        tx_sh <= tx_sh << 1;
      end
    end
  end

  // R5
  idle_clock_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == mode.cpol));
  // R9
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !busy);
endmodule

// File: rtl/spi_buf_master.sv
module spi_buf_master
  import spi_buf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_tx_ie,
  input  logic              cfg_rx_ie,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              st_tx_empty,
  output logic              st_rx_full,
  output logic              st_busy,
  output logic              st_overrun,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  spi_mode_t         mode;
  logic              tx_full, push, load, tick, done, take, rx_full;
  logic [DATA_W-1:0] hold_data, done_word;

  assign mode     = '{cpol: cfg_cpol, cpha: cfg_cpha};
  assign tx_ready = cfg_enable && !tx_full;
  assign push     = tx_valid && tx_ready;
  assign load     = cfg_enable && tx_full && (!st_busy || done);
  assign take     = rx_ready && rx_full;

  spi_tx_holder #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .push(push),
    .push_data(tx_data), .pop(load), .full(tx_full), .data(hold_data)
  );

  spi_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(st_busy), .div(cfg_div), .tick(tick)
  );

  spi_shift_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .mode(mode), .tick(tick),
    .load(load), .load_data(hold_data), .miso(miso), .busy(st_busy),
    .done(done), .word(done_word), .sclk(sclk), .mosi(mosi)
  );

  spi_rx_holder #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .done(done),
    .done_word(done_word), .take(take), .full(rx_full), .data(rx_data),
    .overrun(st_overrun)
  );

  assign rx_valid    = rx_full;
  assign st_rx_full  = rx_full;
  assign st_tx_empty = !tx_full;
  assign irq = (cfg_tx_ie && cfg_enable && !tx_full) || (cfg_rx_ie && rx_full);

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cfg_tx_ie) |-> (cfg_rx_ie && st_rx_full));
  // R2
  load_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cfg_enable) |=> (st_busy || !cfg_enable));
endmodule

// File: tb/tb_spi_buf_master.sv
module tb_spi_buf_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_enable = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [7:0] cfg_div = 8'd1;
  logic       cfg_tx_ie = 1'b0, cfg_rx_ie = 1'b0;
  logic       tx_valid = 1'b0, rx_ready = 1'b0, miso = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, rx_valid, st_tx_empty, st_rx_full, st_busy, st_overrun;
  logic       irq, sclk, mosi;
  logic [7:0] rx_data;

  int checks = 0, fails = 0;
  int cyc = 0;
  int edges, last_cyc, gap_min, gap_max, busy_falls;
  logic [31:0] stream, cap;
  logic prev_busy = 1'b0;
  bit done_flag = 1'b0;

  spi_buf_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_div(cfg_div), .cfg_tx_ie(cfg_tx_ie),
    .cfg_rx_ie(cfg_rx_ie), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .st_tx_empty(st_tx_empty), .st_rx_full(st_rx_full),
    .st_busy(st_busy), .st_overrun(st_overrun), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (prev_busy && !st_busy) busy_falls = busy_falls + 1;
    prev_busy = st_busy;
    if (cyc > 150000 && !done_flag) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // Slave model: samples mosi on the master's sample edge, drives miso on the other.
  always @(sclk) begin
    if (rst_n === 1'b1 && cfg_enable) begin
      automatic bit lead = (sclk !== cfg_cpol);
      automatic bit smp  = cfg_cpha ? !lead : lead;
      edges = edges + 1;
      if (last_cyc >= 0) begin
        if (cyc - last_cyc < gap_min) gap_min = cyc - last_cyc;
        if (cyc - last_cyc > gap_max) gap_max = cyc - last_cyc;
      end
      last_cyc = cyc;
      if (smp) cap = {cap[30:0], mosi};
      if (cfg_cpha && lead) begin
        miso = stream[31];
        stream = stream << 1;
      end
      if (!cfg_cpha && !lead) begin
        stream = stream << 1;
        miso = stream[31];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic slave_prep(input logic [31:0] s);
    stream = s; cap = '0; edges = 0; last_cyc = -1;
    gap_min = 1000000; gap_max = 0; busy_falls = 0;
    if (!cfg_cpha) miso = s[31];
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx();
    int n = 0;
    while (!rx_valid && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic pop_byte(output logic [7:0] b);
    wait_rx();
    b = rx_data;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 busy", st_busy, 0);
    chk("R12 rx_full", st_rx_full, 0);
    chk("R12 overrun", st_overrun, 0);
    chk("R12 tx_empty", st_tx_empty, 1);
    chk("R12 irq", irq, 0);
    chk("R12 sclk", sclk, cfg_cpol);
    chk("R1 ready while disabled", tx_ready, 0);
  endtask

  task automatic t_single(input logic pol, input logic pha, input logic [7:0] div,
                          input logic [7:0] tb_byte, input logic [7:0] sl_byte);
    int busy_cyc = 0;
    logic [7:0] got;
    cfg_cpol = pol; cfg_cpha = pha; cfg_div = div;
    @(negedge clk);
    chk("R5 idle level", sclk, pol);
    slave_prep({sl_byte, 24'h0});
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = tb_byte;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R1 empty falls", st_tx_empty, 0);
    @(negedge clk);
    chk("R2 busy on load", st_busy, 1);
    chk("R2 empty on load", st_tx_empty, 1);
    busy_cyc = 1;
    while (!rx_valid && busy_cyc < 5000) begin
      @(negedge clk);
      if (st_busy) busy_cyc++;
    end
    chk("R9 busy length", busy_cyc, 16 * (div + 1));
    chk("R9 busy low at end", st_busy, 0);
    chk("R3 rx byte", rx_data, sl_byte);
    chk("R4 mosi byte seen at sample edge", cap[7:0], tb_byte);
    chk("R5 transitions", edges, 16);
    chk("R5 half period", gap_max, div + 1);
    chk("R5 back to idle", sclk, pol);
    chk("R6 rx_full", st_rx_full, 1);
    pop_byte(got);
    chk("R6 cleared by take", rx_valid, 0);
  endtask

  task automatic t_back_to_back();
    logic [7:0] a, b;
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_div = 8'd2;
    @(negedge clk);
    slave_prep({8'h5A, 8'hC3, 16'h0});
    push_byte(8'h81);
    push_byte(8'h7E);
    pop_byte(a);
    pop_byte(b);
    @(negedge clk);
    chk("R8 first rx", a, 8'h5A);
    chk("R8 second rx", b, 8'hC3);
    chk("R8 mosi pair", cap[15:0], 16'h817E);
    chk("R8 transitions", edges, 32);
    chk("R8 min spacing", gap_min, 3);
    chk("R8 max spacing", gap_max, 3);
    chk("R8 busy stayed high", busy_falls, 1);
  endtask

  task automatic t_overrun();
    logic [7:0] g;
    cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_div = 8'd1;
    @(negedge clk);
    slave_prep({8'h11, 8'h22, 16'h0});
    push_byte(8'hAA);
    push_byte(8'hBB);
    wait_rx();
    while (st_busy) @(negedge clk);
    chk("R7 overrun set", st_overrun, 1);
    chk("R7 newest byte kept", rx_data, 8'h22);
    pop_byte(g);
    chk("R7 overrun cleared by take", st_overrun, 0);
  endtask

  task automatic t_irq();
    logic [7:0] g;
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_div = 8'd0;
    cfg_tx_ie = 1'b0; cfg_rx_ie = 1'b0;
    @(negedge clk);
    chk("R10 masked idle", irq, 0);
    cfg_tx_ie = 1'b1;
    @(negedge clk);
    chk("R10 tx cause", irq, 1);
    slave_prep({8'h96, 24'h0});
    push_byte(8'h3C);
    chk("R10 tx cause clears on write", irq, 0);
    @(negedge clk);
    chk("R10 tx cause returns on load", irq, 1);
    cfg_tx_ie = 1'b0;
    wait_rx();
    @(negedge clk);
    chk("R10 rx masked", irq, 0);
    cfg_rx_ie = 1'b1;
    @(negedge clk);
    chk("R10 rx cause", irq, 1);
    pop_byte(g);
    chk("R10 rx cause clears", irq, 0);
    cfg_rx_ie = 1'b0;
  endtask

  task automatic t_disable();
    cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_div = 8'd3;
    @(negedge clk);
    slave_prep({8'hE7, 24'h0});
    push_byte(8'h55);
    wait_rx();
    slave_prep(32'h0);
    push_byte(8'h12);
    push_byte(8'h34);
    repeat (20) @(negedge clk);
    chk("R11 was busy", st_busy, 1);
    cfg_enable = 1'b0;
    @(negedge clk);
    chk("R11 busy aborted", st_busy, 0);
    chk("R11 tx flushed", st_tx_empty, 1);
    chk("R11 rx flushed", rx_valid, 0);
    chk("R11 sclk idle", sclk, 1);
    chk("R1 not ready disabled", tx_ready, 0);
    cfg_enable = 1'b1;
    repeat (100) @(negedge clk);
    chk("R11 waiting byte not sent", st_busy, 0);
    chk("R11 nothing received", rx_valid, 0);
  endtask

  initial begin
    slave_prep(32'h0);
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    cfg_enable = 1'b1;
    @(negedge clk);
    chk("R1 ready when enabled", tx_ready, 1);
    t_single(1'b0, 1'b0, 8'd1, 8'hA5, 8'h3C);
    t_single(1'b0, 1'b1, 8'd1, 8'h96, 8'hD2);
    t_single(1'b1, 1'b0, 8'd2, 8'h01, 8'h80);
    t_single(1'b1, 1'b1, 8'd0, 8'hF0, 8'h0F);
    t_back_to_back();
    t_overrun();
    t_irq();
    t_disable();
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule